// File: doc/BRIEF.md
# Receive Buffer Size Encoder and Checker

This block handles the 16-bit receive-count descriptor word of an endpoint. Its encoder turns a buffer size in bytes into a granularity flag and a block count. Small buffers are allocated in 2-byte blocks. Large buffers are allocated in 32-byte blocks, and that count is stored one lower than the number of blocks. Its decoder turns the high six bits of a descriptor back into the capacity in bytes.

A small receive state machine uses that capacity while a packet is arriving. On a packet-start strobe it latches the descriptor header and its capacity, then counts byte-valid strobes. The running count appears in the low field of a status word. If a byte arrives after the buffer is full, the machine sets an overflow flag and holds the count at the capacity.

The state machine has three states:
- ST_IDLE waits, keeping the last result.
- ST_RECV counts bytes.
- ST_FULL has seen an overflow and ignores further bytes.

Its transitions are:
- START: any state to ST_RECV on pkt_start.
- SPILL: ST_RECV to ST_FULL on a byte arriving at capacity.
- FINISH: ST_RECV or ST_FULL to ST_IDLE on pkt_end.

Top module: `rxbuf_sizer`

## Requirements
- R1: For a request above 62 bytes and at most 1023 bytes, enc_word bit 15 is 1. Bits 14:10 hold the request divided by 32, minus one when the request is an exact multiple of 32. Bits 9:0 are zero and enc_invalid is 0.
- R2: For a request of 0 to 62 bytes, enc_word bit 15 is 0, bits 14:10 hold the request divided by 2 rounded up, and bits 9:0 are zero.
- R3: A request above 1023 bytes drives enc_invalid to 1 and enc_word to zero.
- R4: capacity is combinational from desc_word. Let n be bits 14:10. The capacity is (n+1)*32 when bit 15 is 1, and n*2 when bit 15 is 0.
- R5: In the cycle after pkt_start, the count is zero and overflow is 0. status_word bits 15:10 then equal desc_word bits 15:10 as sampled at the start. pkt_start takes priority over every other input in the same cycle.
- R6: In ST_RECV, each cycle with byte_valid high and the count below the latched capacity raises the count by one. The new count is visible in status_word bits 9:0 after that clock edge. A byte arriving in the same cycle as pkt_end is counted.
- R7: The first byte that arrives when the count already equals the capacity sets overflow after that edge, and the count stays at the capacity. Overflow and the count then hold until the next pkt_start.
- R8: A descriptor with bit 15 at 0 and bits 14:10 at 0 has zero capacity, so the first byte received sets overflow and the count stays 0.
- R9: byte_valid has no effect in ST_IDLE, either before any packet or after pkt_end. The count and overflow keep their values.
- R10: status_word bits 9:0 show the count saturated at 1023, so a full 1024-byte buffer reads 1023.
- R11: After reset, status_word is zero, overflow is 0 and the machine is in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_bytes | input | 11 | Requested buffer size in bytes |
| enc_word | output | 16 | Encoded descriptor (flag, block count, zero count field) |
| enc_invalid | output | 1 | Request exceeds 1023 bytes |
| desc_word | input | 16 | Descriptor used by the checker; only bits 15:10 matter |
| capacity | output | 11 | Decoded capacity of desc_word in bytes |
| pkt_start | input | 1 | Packet start strobe; clears and arms the counter |
| byte_valid | input | 1 | One received byte this cycle |
| pkt_end | input | 1 | Packet end strobe |
| status_word | output | 16 | Latched header bits with received count in bits 9:0 |
| overflow | output | 1 | Sticky flag: a byte arrived beyond capacity |

## Verification
The encoder and the capacity decoder are combinational. Their results are due in the same cycle as the input, so the bench sets the input at a falling edge and reads the result at the next falling edge. Every strobe into the state machine passes through one register. The count, the overflow flag and the latched header are therefore due one rising edge after the strobe, and the bench samples them at the falling edge that follows that rising edge. Each ignore case is checked the same way, one edge after the stray byte.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
    localparam int WORD_W    = 16;
    localparam int CNT_W     = 10;
    localparam int BLK_W     = 5;
    localparam int REQ_W     = 11;
    localparam int CAP_W     = CNT_W + 1;
    localparam int BLK_LSB   = CNT_W;
    localparam int BIG_BIT   = WORD_W - 1;
    localparam int HDR_W     = WORD_W - CNT_W;
    localparam int BIG_LOG2  = 5;
    localparam int SMALL_MAX = 2 * ((1 << BLK_W) - 1);
    localparam int MAX_REQ   = (1 << CNT_W) - 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_FULL = 2'd2
    } rx_state_e;

    function automatic logic [CAP_W-1:0] hdr_capacity(input logic [HDR_W-1:0] hdr);
        logic [CAP_W-1:0] n;
        n = CAP_W'(hdr[BLK_W-1:0]);
        if (hdr[HDR_W-1])
            hdr_capacity = (n + CAP_W'(1)) << BIG_LOG2;
        else
            hdr_capacity = n << 1;
    endfunction
endpackage

// File: rtl/rxbuf_size_enc.sv
module rxbuf_size_enc
    import rxbuf_pkg::*;
(
    input  logic [REQ_W-1:0]  req,
    output logic [WORD_W-1:0] word,
    output logic              invalid
);
    logic [REQ_W-1:0] blocks;

    always_comb begin
        word    = '0;
        invalid = 1'b0;
        blocks  = '0;
        if (req > REQ_W'(MAX_REQ)) begin
            invalid = 1'b1;
        end else if (req > REQ_W'(SMALL_MAX)) begin
            blocks = req >> BIG_LOG2;
            if (req[BIG_LOG2-1:0] == '0)
                blocks = blocks - REQ_W'(1);
            word[BIG_BIT] = 1'b1;
            word[BLK_LSB +: BLK_W] = blocks[BLK_W-1:0];
        end else begin
            blocks = (req >> 1) + REQ_W'(req[0]);
            word[BLK_LSB +: BLK_W] = blocks[BLK_W-1:0];
        end
    end
endmodule

// File: rtl/rxbuf_cap_dec.sv
module rxbuf_cap_dec
    import rxbuf_pkg::*;
(
    input  logic [HDR_W-1:0] hdr,
    output logic [CAP_W-1:0] cap
);
    always_comb cap = hdr_capacity(hdr);
endmodule

// File: rtl/rxbuf_rx_fsm.sv
module rxbuf_rx_fsm
    import rxbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start,
    input  logic              byte_valid,
    input  logic              pkt_end,
    input  logic [HDR_W-1:0]  hdr_in,
    input  logic [CAP_W-1:0]  cap_in,
    output logic [WORD_W-1:0] status_word,
    output logic              overflow
);
    rx_state_e        state_q, state_d;
    logic [CAP_W-1:0] cnt_q, cap_q;
    logic [HDR_W-1:0] hdr_q;
    logic             ovf_q;
    logic             at_cap, take, spill;

    assign at_cap = (cnt_q == cap_q);
    assign take   = (state_q == ST_RECV) && byte_valid && !at_cap;
    assign spill  = (state_q == ST_RECV) && byte_valid && at_cap;

    always_comb begin
        state_d = state_q;
        if (pkt_start) begin
            state_d = ST_RECV;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RECV: begin
                    if (pkt_end)    state_d = ST_IDLE;
                    else if (spill) state_d = ST_FULL;
                end
                ST_FULL: if (pkt_end) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cap_q <= '0;
            hdr_q <= '0;
            ovf_q <= 1'b0;
        end else if (pkt_start) begin
            cnt_q <= '0;
            cap_q <= cap_in;
            hdr_q <= hdr_in;
            ovf_q <= 1'b0;
        end else begin
            if (take)  cnt_q <= cnt_q + CAP_W'(1);
            if (spill) ovf_q <= 1'b1;
        end
    end

    always_comb begin
        status_word[WORD_W-1:CNT_W] = hdr_q;
        if (cnt_q > CAP_W'(MAX_REQ)) status_word[CNT_W-1:0] = CNT_W'(MAX_REQ);
        else                         status_word[CNT_W-1:0] = cnt_q[CNT_W-1:0];
        overflow = ovf_q;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cap_q); // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |=> (cnt_q == '0) && !ovf_q && (state_q == ST_RECV)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q && !pkt_start |=> ovf_q); // R7
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && !pkt_start |=> $stable(cnt_q) && $stable(ovf_q)); // R9
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECV) && byte_valid && !pkt_start && (cnt_q < cap_q)
        |=> cnt_q == $past(cnt_q) + CAP_W'(1)); // R6
    AST_FULL_HAS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) |-> ovf_q); // R7
endmodule

// File: rtl/rxbuf_sizer.sv
module rxbuf_sizer
    import rxbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REQ_W-1:0]  req_bytes,
    output logic [WORD_W-1:0] enc_word,
    output logic              enc_invalid,
    input  logic [WORD_W-1:0] desc_word,
    output logic [CAP_W-1:0]  capacity,
    input  logic              pkt_start,
    input  logic              byte_valid,
    input  logic              pkt_end,
    output logic [WORD_W-1:0] status_word,
    output logic              overflow
);
    logic unused_desc_low;
    assign unused_desc_low = ^desc_word[CNT_W-1:0];

    rxbuf_size_enc u_enc (
        .req     (req_bytes),
        .word    (enc_word),
        .invalid (enc_invalid)
    );

    rxbuf_cap_dec u_dec (
        .hdr (desc_word[WORD_W-1:CNT_W]),
        .cap (capacity)
    );

    rxbuf_rx_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pkt_start   (pkt_start),
        .byte_valid  (byte_valid),
        .pkt_end     (pkt_end),
        .hdr_in      (desc_word[WORD_W-1:CNT_W]),
        .cap_in      (capacity),
        .status_word (status_word),
        .overflow    (overflow)
    );

    always_comb begin
        if (rst_n && !enc_invalid && !$isunknown(req_bytes)) begin
            AST_ENC_COVERS: assert (hdr_capacity(enc_word[WORD_W-1:CNT_W]) >= CAP_W'(req_bytes)); // R1
            AST_ENC_SMALL_FLAG: assert ((req_bytes > REQ_W'(SMALL_MAX)) == enc_word[BIG_BIT]); // R2
        end
    end
endmodule

// File: tb/rxbuf_sizer_tb.sv
module rxbuf_sizer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] req_bytes = '0;
    logic [15:0] enc_word;
    logic        enc_invalid;
    logic [15:0] desc_word = '0;
    logic [10:0] capacity;
    logic        pkt_start = 1'b0;
    logic        byte_valid = 1'b0;
    logic        pkt_end = 1'b0;
    logic [15:0] status_word;
    logic        overflow;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rxbuf_sizer u_dut (
        .clk (clk), .rst_n (rst_n), .req_bytes (req_bytes),
        .enc_word (enc_word), .enc_invalid (enc_invalid),
        .desc_word (desc_word), .capacity (capacity),
        .pkt_start (pkt_start), .byte_valid (byte_valid), .pkt_end (pkt_end),
        .status_word (status_word), .overflow (overflow)
    );

    localparam int NV = 12;
    localparam logic [10:0] VREQ [NV] = '{11'd0, 11'd1, 11'd2, 11'd61, 11'd62, 11'd63,
                                          11'd64, 11'd65, 11'd96, 11'd1023, 11'd1024, 11'd2047};
    localparam logic [15:0] VWORD[NV] = '{16'h0000, 16'h0400, 16'h0400, 16'h7C00, 16'h7C00, 16'h8400,
                                          16'h8400, 16'h8800, 16'h8800, 16'hFC00, 16'h0000, 16'h0000};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_cap(input logic [15:0] w);
        if (w[15]) return (int'(w[14:10]) + 1) * 32;
        return int'(w[14:10]) * 2;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_pkt(input logic [15:0] d);
        desc_word = d;
        pkt_start = 1'b1;
        tick();
        pkt_start = 1'b0;
    endtask

    task automatic bytes(input int n);
        byte_valid = 1'b1;
        for (int i = 0; i < n; i++) tick();
        byte_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk("R11 status after reset", 32'(status_word), 0);
        chk("R11 overflow after reset", 32'(overflow), 0);
        tick();
        rst_n = 1'b1;
        tick();

        // R1 R2 R3: encoder vector table, capacity round-trip for R4
        for (int i = 0; i < NV; i++) begin
            req_bytes = VREQ[i];
            desc_word = VWORD[i];
            @(negedge clk);
            chk(VREQ[i] > 62 ? "R1 enc word" : "R2 enc word", 32'(enc_word), 32'(VWORD[i]));
            chk("R3 enc invalid", 32'(enc_invalid), 32'(VREQ[i] > 1023));
            chk("R4 capacity", 32'(capacity), 32'(exp_cap(VWORD[i])));
        end
        desc_word = 16'h8000;
        @(negedge clk);
        chk("R4 one large block", 32'(capacity), 32);

        // R9: byte before any packet
        bytes(1);
        chk("R9 idle byte ignored count", 32'(status_word), 0);
        chk("R9 idle byte ignored ovf", 32'(overflow), 0);

        // R5 R6 R7: capacity 2
        start_pkt(16'h0400);
        chk("R5 header latched, count zero", 32'(status_word), 32'h0400);
        bytes(1);
        chk("R6 first byte", 32'(status_word), 32'h0401);
        bytes(1);
        chk("R6 at capacity", 32'(status_word), 32'h0402);
        chk("R7 no overflow at capacity", 32'(overflow), 0);
        bytes(1);
        chk("R7 overflow on extra byte", 32'(overflow), 1);
        chk("R7 count saturated", 32'(status_word), 32'h0402);
        bytes(3);
        chk("R7 count still held", 32'(status_word), 32'h0402);
        chk("R7 overflow sticky", 32'(overflow), 1);
        pkt_end = 1'b1; tick(); pkt_end = 1'b0;
        chk("R7 overflow kept after end", 32'(overflow), 1);

        // R5: restart clears; R6 byte with pkt_end counted; R9 ignored after end
        start_pkt(16'h8400);
        chk("R5 restart clears overflow", 32'(overflow), 0);
        chk("R5 restart header", 32'(status_word), 32'h8400);
        bytes(4);
        pkt_end = 1'b1; byte_valid = 1'b1; tick(); pkt_end = 1'b0; byte_valid = 1'b0;
        chk("R6 byte with pkt_end counted", 32'(status_word), 32'h8405);
        bytes(2);
        chk("R9 bytes after end ignored", 32'(status_word), 32'h8405);

        // R5: pkt_start wins over byte_valid
        desc_word = 16'h0800;
        pkt_start = 1'b1; byte_valid = 1'b1; tick(); pkt_start = 1'b0; byte_valid = 1'b0;
        chk("R5 start priority", 32'(status_word), 32'h0800);

        // R8: zero capacity
        start_pkt(16'h0000);
        bytes(1);
        chk("R8 zero capacity overflows", 32'(overflow), 1);
        chk("R8 count stays zero", 32'(status_word), 0);

        // R10: 1024-byte buffer
        start_pkt(16'hFC00);
        bytes(1023);
        chk("R6 1023 bytes", 32'(status_word), 32'hFFFF);
        bytes(1);
        chk("R10 full buffer reads 1023", 32'(status_word), 32'hFFFF);
        chk("R10 no overflow at 1024", 32'(overflow), 0);
        bytes(1);
        chk("R7 overflow beyond 1024", 32'(overflow), 1);

        // R11: reset mid-packet
        start_pkt(16'h0400);
        bytes(1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 reset clears status", 32'(status_word), 0);
        chk("R11 reset clears overflow", 32'(overflow), 0);
        rst_n = 1'b1;
        bytes(1);
        chk("R11 idle after reset", 32'(status_word), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule